// File: doc/BRIEF.md
# Indirect Local-Memory Test Access Unit

This unit lets software reach local SRAM without a direct load or store path. Software first writes up to two 32-bit data words. It then writes a command word. The unit scatters the command's fields into a physical SRAM address: way select, instruction/data half, bank, subbank and line offset are each placed on their own address bits, and the result is combined with a fixed SRAM base. It then performs a single 64-bit read or write on a simple request/acknowledge memory port.

A write command sends both data words to memory, with the low word in bits 31:0. A read command loads the returned 64-bit word back into the two data words. Some commands are rejected: a command with a reserved bit set, or one that asks for the tag array instead of the data array. A rejected command starts no memory access and raises a sticky error flag. Software clears each flag by writing one to it.

The register window is selected by a 3-bit word index:

| Index | Register |
|-------|----------|
| 0 | SRAM base |
| 1 | command |
| 2 | low data word |
| 3 | high data word |
| 4 | status |

Reads are combinational. Writes take effect on the clock edge.

Top module: `lmem_test_access`

## Requirements
- R1: After reset the base register reads 0xFF800000. The command register, both data words and the status register read 0, and `mem_req` is low.
- R2: Writes to the base register (index 0) are discarded. The register keeps reading 0xFF800000.
- R3: The access address is the base OR-ed with remapped command bits:
  - command bit 26 goes to address bit 11;
  - bit 24 goes to address bit 21;
  - bit 23 goes to address bit 15;
  - bits 17:16 go to address bits 13:12;
  - bits 14 and 10:3 go to the same address bit positions.
- R4: A command write of zero is stored and reads back as zero, but it starts no memory access.
- R5: A nonzero command with any bit of 0xFA7CB801 set is stored, starts no access, and sets status bit 1 (reserved-bit error).
- R6: A nonzero command with bit 2 (data-array select) clear is stored, starts no access, and sets status bit 2 (tag-array error).
- R7: A legal command with bit 1 set writes 64 bits to memory. The write data is {high data word, low data word}.
- R8: A legal command with bit 1 clear reads 64 bits. Memory bits 31:0 go to the low data word and bits 63:32 go to the high data word.
- R9: Status bit 0 (busy) is high from the accepted command write until the memory acknowledge. During that time `mem_req` stays high and `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R10: While busy, writes to the command register and to both data words are ignored.
- R11: The error bits are sticky. A later legal command does not clear them. Writing one to status bit 1 or bit 2 clears only that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Memory read data, valid with `mem_ack` |

## Verification
The hardest case to reach from the ports is a register write that lands while a transfer is still in flight. Such a write must not disturb the data words or the held request. To reach it, the bench's memory model delays its acknowledge by several cycles. During that window the stimulus writes a new command and a new low data word, then checks that the request address is unchanged. After completion it checks that the data words hold the memory value. Each command field is also driven alone, one bit at a time, so that a swapped or misplaced address bit shows up as its own address mismatch.

// File: rtl/lmta_pkg.sv
package lmta_pkg;
    localparam int CFG_AW     = 3;
    localparam int WORD_W     = 32;
    localparam int MEM_DW     = 64;
    localparam int NUM_WORDS  = MEM_DW / WORD_W;

    localparam logic [WORD_W-1:0] CMD_RSVD_MASK = 32'hFA7C_B801;
    localparam logic [WORD_W-1:0] CMD_PASS_MASK = 32'h0000_47F8;
    localparam int CMD_WR_BIT    = 1;
    localparam int CMD_ARRAY_BIT = 2;

    localparam int ST_BUSY = 0;
    localparam int ST_RSVD = 1;
    localparam int ST_TAG  = 2;

    typedef enum logic [CFG_AW-1:0] {
        SEL_BASE = 3'd0,
        SEL_CMD  = 3'd1,
        SEL_DLO  = 3'd2,
        SEL_DHI  = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    typedef enum logic {XS_IDLE, XS_WAIT} xfer_state_e;

    typedef struct packed {
        logic              go;
        logic              rsvd_err;
        logic              tag_err;
        logic              wr;
        logic [WORD_W-1:0] addr;
    } cmd_dec_t;

    function automatic logic [WORD_W-1:0] scatter_addr(
        input logic [WORD_W-1:0] base,
        input logic [WORD_W-1:0] cmd
    );
        logic [WORD_W-1:0] a;
        a        = base | (cmd & CMD_PASS_MASK);
        a[11]    = a[11] | cmd[26];
        a[21]    = a[21] | cmd[24];
        a[15]    = a[15] | cmd[23];
        a[13:12] = a[13:12] | cmd[17:16];
        return a;
    endfunction
endpackage

// File: rtl/lmta_cmd_decode.sv
module lmta_cmd_decode
    import lmta_pkg::*;
#(
    parameter logic [WORD_W-1:0] BASE_ADDR = 32'hFF80_0000
) (
    input  logic [WORD_W-1:0] cmd,
    output cmd_dec_t          dec
);
    logic nonzero;

    always_comb begin
        nonzero      = |cmd;
        dec.rsvd_err = |(cmd & CMD_RSVD_MASK);
        dec.tag_err  = nonzero && !cmd[CMD_ARRAY_BIT];
        dec.go       = nonzero && !dec.rsvd_err && !dec.tag_err;
        dec.wr       = cmd[CMD_WR_BIT];
        dec.addr     = scatter_addr(BASE_ADDR, cmd);
    end
endmodule

// File: rtl/lmta_data_regs.sv
module lmta_data_regs
    import lmta_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NW = NUM_WORDS,
    localparam int DW = W * NW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [W-1:0]      cfg_wdata,
    input  logic              load,
    input  logic [DW-1:0]     load_data,
    output logic [DW-1:0]     data_q
);
    for (genvar i = 0; i < NW; i++) begin : g_word
        logic sel;
        assign sel = cfg_we && !busy && (cfg_addr == CFG_AW'(SEL_DLO) + CFG_AW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[i*W +: W] <= '0;
            end else if (load) begin
                data_q[i*W +: W] <= load_data[i*W +: W];
            end else if (sel) begin
                data_q[i*W +: W] <= cfg_wdata;
            end
        end
    end

    assert_data_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> $stable(data_q));
endmodule

// File: rtl/lmta_xfer_ctrl.sv
module lmta_xfer_ctrl
    import lmta_pkg::*;
#(
    parameter int AW = WORD_W,
    parameter int DW = MEM_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          rd_done
);
    xfer_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= XS_IDLE;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            case (state_q)
                XS_IDLE: if (start) begin
                    state_q   <= XS_WAIT;
                    mem_we    <= start_we;
                    mem_addr  <= start_addr;
                    mem_wdata <= start_wdata;
                end
                XS_WAIT: if (mem_ack) begin
                    state_q <= XS_IDLE;
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign mem_req = (state_q == XS_WAIT);
    assign busy    = mem_req;
    assign rd_done = mem_req && mem_ack && !mem_we;

    assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/lmem_test_access.sv
module lmem_test_access
    import lmta_pkg::*;
#(
    parameter logic [WORD_W-1:0] BASE_ADDR = 32'hFF80_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [MEM_DW-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [MEM_DW-1:0] mem_rdata
);
    cmd_dec_t          dec;
    logic [WORD_W-1:0] cmd_q;
    logic [MEM_DW-1:0] data_q;
    logic              busy, rd_done;
    logic              cmd_wr, stat_wr, start;
    logic              rsvd_q, tag_q;

    assign cmd_wr  = cfg_we && (cfg_addr == CFG_AW'(SEL_CMD)) && !busy;
    assign stat_wr = cfg_we && (cfg_addr == CFG_AW'(SEL_STAT));
    assign start   = cmd_wr && dec.go;

    lmta_cmd_decode #(.BASE_ADDR(BASE_ADDR)) i_dec (
        .cmd (cfg_wdata),
        .dec (dec)
    );

    lmta_data_regs #(.W(WORD_W), .NW(NUM_WORDS)) i_data (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .load      (rd_done),
        .load_data (mem_rdata),
        .data_q    (data_q)
    );

    lmta_xfer_ctrl #(.AW(WORD_W), .DW(MEM_DW)) i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_we    (dec.wr),
        .start_addr  (dec.addr),
        .start_wdata (data_q),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .busy        (busy),
        .rd_done     (rd_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            rsvd_q <= 1'b0;
            tag_q  <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd_q <= cfg_wdata;
            end
            if (cmd_wr && dec.rsvd_err) begin
                rsvd_q <= 1'b1;
            end else if (stat_wr && cfg_wdata[ST_RSVD]) begin
                rsvd_q <= 1'b0;
            end
            if (cmd_wr && dec.tag_err) begin
                tag_q <= 1'b1;
            end else if (stat_wr && cfg_wdata[ST_TAG]) begin
                tag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            CFG_AW'(SEL_BASE): cfg_rdata = BASE_ADDR;
            CFG_AW'(SEL_CMD):  cfg_rdata = cmd_q;
            CFG_AW'(SEL_DLO):  cfg_rdata = data_q[0 +: WORD_W];
            CFG_AW'(SEL_DHI):  cfg_rdata = data_q[WORD_W +: WORD_W];
            CFG_AW'(SEL_STAT): begin
                cfg_rdata[ST_BUSY] = busy;
                cfg_rdata[ST_RSVD] = rsvd_q;
                cfg_rdata[ST_TAG]  = tag_q;
            end
            default: cfg_rdata = '0;
        endcase
    end

    assert_zero_cmd_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cfg_wdata == '0) |=> !mem_req);
    assert_rsvd_no_access_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && dec.rsvd_err) |=> !mem_req);
    assert_tag_no_access_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && dec.tag_err) |=> !mem_req);
    assert_base_in_addr_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((mem_addr & BASE_ADDR) == BASE_ADDR));
    assert_rsvd_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (rsvd_q && !(stat_wr && cfg_wdata[ST_RSVD])) |=> rsvd_q);
endmodule

// File: tb/test_lmem_test_access.sv
module test_lmem_test_access;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'hFF80_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int ack_delay = 1;
    int wait_cnt = 0;
    int xfer_count = 0;
    logic [31:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic [63:0] last_wdata = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmem_test_access i_lmem_test_access (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] pat(input logic [31:0] a);
        return {a ^ 32'hC3C3_0F0F, ~a};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] c);
        logic [31:0] a;
        a = BASE;
        if (c[26]) a[11] = 1'b1;
        if (c[24]) a[21] = 1'b1;
        if (c[23]) a[15] = 1'b1;
        if (c[17]) a[13] = 1'b1;
        if (c[16]) a[12] = 1'b1;
        if (c[14]) a[14] = 1'b1;
        for (int b = 3; b <= 10; b++) if (c[b]) a[b] = 1'b1;
        return a;
    endfunction

    // memory model: acknowledge after ack_delay falling edges
    always @(negedge clk) begin
        if (!mem_req) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (!mem_ack) begin
            wait_cnt++;
            if (wait_cnt >= ack_delay) begin
                mem_ack    = 1'b1;
                mem_rdata  = pat(mem_addr);
                xfer_count++;
                last_addr  = mem_addr;
                last_we    = mem_we;
                last_wdata = mem_wdata;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            cfg_read(3'd4, s);
            if (!s[0]) return;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        cfg_read(3'd0, v); check("R1 base", v, BASE);
        cfg_read(3'd1, v); check("R1 cmd", v, 0);
        cfg_read(3'd2, v); check("R1 dlo", v, 0);
        cfg_read(3'd3, v); check("R1 dhi", v, 0);
        cfg_read(3'd4, v); check("R1 status", v, 0);
        check("R1 mem_req", mem_req, 0);
    endtask

    task automatic t_base_ro();
        logic [31:0] v;
        cfg_write(3'd0, 32'h1234_5678);
        cfg_read(3'd0, v); check("R2 base ignores write", v, BASE);
    endtask

    task automatic t_write_xfer();
        logic [31:0] c;
        int n;
        c = 32'h0583_47FE;
        ack_delay = 2;
        cfg_write(3'd2, 32'h1122_3344);
        cfg_write(3'd3, 32'h5566_7788);
        n = xfer_count;
        cfg_write(3'd1, c);
        wait_idle();
        check("R7 one access", 64'(xfer_count - n), 1);
        check("R7 write flag", last_we, 1);
        check("R7 wdata", last_wdata, 64'h5566_7788_1122_3344);
        check("R3 full field address", last_addr, exp_addr(c));
    endtask

    task automatic t_read_busy();
        logic [31:0] c, v;
        c = 32'h0001_0124;
        ack_delay = 6;
        cfg_write(3'd1, c);
        cfg_read(3'd4, v); check("R9 busy set", v[0], 1);
        check("R9 mem_req high", mem_req, 1);
        cfg_write(3'd2, 32'hDEAD_BEEF);
        cfg_write(3'd1, 32'h0000_0404);
        check("R9 addr held", mem_addr, exp_addr(c));
        check("R9 still requesting", mem_req, 1);
        wait_idle();
        cfg_read(3'd4, v); check("R9 busy cleared", v[0], 0);
        cfg_read(3'd2, v); check("R8 low word", v, pat(exp_addr(c))[31:0]);
        cfg_read(3'd3, v); check("R8 high word", v, pat(exp_addr(c))[63:32]);
        cfg_read(3'd1, v); check("R10 cmd ignored while busy", v, c);
        check("R8 read flag", last_we, 0);
    endtask

    task automatic t_addr_map();
        int src[8] = '{26, 24, 23, 17, 16, 14, 10, 3};
        int dst[8] = '{11, 21, 15, 13, 12, 14, 10, 3};
        ack_delay = 1;
        for (int k = 0; k < 8; k++) begin
            cfg_write(3'd1, 32'h4 | (32'h1 << src[k]));
            wait_idle();
            check("R3 bit map", last_addr, BASE | (32'h1 << dst[k]));
        end
    endtask

    task automatic t_zero_cmd();
        logic [31:0] v;
        int n;
        n = xfer_count;
        cfg_write(3'd1, 32'h0);
        repeat (4) @(negedge clk);
        check("R4 no access", 64'(xfer_count - n), 0);
        cfg_read(3'd1, v); check("R4 stored", v, 0);
    endtask

    task automatic t_rsvd();
        logic [31:0] v;
        int n;
        n = xfer_count;
        cfg_write(3'd1, 32'h8000_0004);
        check("R5 no request", mem_req, 0);
        repeat (3) @(negedge clk);
        check("R5 no access", 64'(xfer_count - n), 0);
        cfg_read(3'd4, v); check("R5 status", v, 32'h2);
        cfg_read(3'd1, v); check("R5 stored", v, 32'h8000_0004);
    endtask

    task automatic t_tag();
        logic [31:0] v;
        int n;
        n = xfer_count;
        cfg_write(3'd1, 32'h0000_0008);
        repeat (3) @(negedge clk);
        check("R6 no access", 64'(xfer_count - n), 0);
        cfg_read(3'd4, v); check("R6 status tag + R11 rsvd kept", v, 32'h6);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        cfg_write(3'd1, 32'h0000_0004);
        wait_idle();
        cfg_read(3'd4, v); check("R11 survive legal cmd", v, 32'h6);
        cfg_write(3'd4, 32'h2);
        cfg_read(3'd4, v); check("R11 clear rsvd only", v, 32'h4);
        cfg_write(3'd4, 32'h4);
        cfg_read(3'd4, v); check("R11 clear tag", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_base_ro();
        t_write_xfer();
        t_read_busy();
        t_addr_map();
        t_zero_cmd();
        t_rsvd();
        t_tag();
        t_sticky();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule